// File: doc/BRIEF.md
# Multiplexed Narrow-Bus Access Sequencer

This block turns one internal memory request into a train of external cycles on a shared 16-line address/data bus. A request carries a 24-bit address, a size (byte, half-word or word), a direction, 32 bits of write data and the index of one of four memory blocks. Blocks that are configured as 8 bits wide get one external cycle per byte, lowest byte first. Blocks that are 16 bits wide get one cycle per half-word. Each external cycle has a one-clock address phase with a latch strobe, then a data phase whose length is fixed per block, then one clock with every chip select negated. The shared lines float whenever no chip select is active.

Read bytes are gathered into a 32-bit result at the lanes selected by their address. A one-clock completion pulse comes after the last cycle. Another bus master may ask for the bus. The grant is only given between whole requests, and while the bus is granted the shared lines are either released to a pull-up or left floating, as a configuration input selects.

Top module: `nbus_seq`

## Requirements
- R1: On an 8-bit block, a byte request makes one external cycle at its own address. A half-word makes two cycles with address bit 0 = 0, then 1. A word makes four cycles with address bits [1:0] = 00, 01, 10, 11 in that order. The other address bits come from the request.
- R2: On an 8-bit block, write data is driven on ad_o[7:0] with ad_o[15:8] = 0, and only we_n[0] is pulled low (we_n = 2'b10). The byte comes from req_wdata lane A[1:0] of that cycle. The read and write strobes are never low together.
- R3: Read data is written into rdata byte lane A[1:0] of each cycle, and unread lanes are 0. rdata is valid while done is high.
- R4: Each external cycle has an address phase of exactly one clock with ale = 1, the selected cs_n bit low, ad_o = A[15:0] driven and addr_hi = A[23:16]. Then come the data cycles and one gap clock with all cs_n high. done is high N*(W+3) clocks after the accepting edge, where N is the cycle count and W is the block's wait value.
- R5: The data phase of every cycle lasts W+1 clocks, with W read from cfg_wait[3*b +: 3] for block b when the request was accepted.
- R6: ad_oe is 0 whenever all cs_n are high, and it is also 0 during a read data phase.
- R7: addr_hi is 0 on every clock that is not an address phase.
- R8: Block 0 is 8 bits wide when strap_mode = 2'b10, and 16 bits wide otherwise. Block b (1..3) is 8 bits wide when cfg_bw[b-1] = 0.
- R9: On a 16-bit block, a byte or half-word makes one cycle and a word makes two cycles (A[1:0] = 00, then 10). Each cycle drives the req_wdata half selected by A[1] on ad_o[15:0]. Half-word and word cycles pull both we_n bits low. A byte pulls only we_n[A[0]] low. Read halves go into rdata half A[1], and a read byte goes into lane A[1:0] from pin lane A[0].
- R10: rel_gnt never rises during a request. If rel_req is high at the gap clock of the last cycle, rel_gnt is high on the next clock.
- R11: While rel_gnt is high, all cs_n are high, ad_oe = 0, req_ready = 0 and no request is accepted. ad_pull_en equals cfg_rel_pullup.
- R12: done is a single-clock pulse, and req_ready is high on the clock after it.
- R13: When idle with rel_req and req_valid both high, the bus is granted and the request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data by lane |
| req_blk | input | 2 | Memory block index |
| done | output | 1 | Request complete pulse |
| rdata | output | 32 | Assembled read data |
| strap_mode | input | 2 | Mode straps giving block 0 width |
| cfg_bw | input | 3 | Width bits of blocks 1..3 (0 = 8-bit) |
| cfg_wait | input | 12 | Wait value per block, 3 bits each |
| cfg_rel_pullup | input | 1 | Pull shared lines up while released |
| rel_req | input | 1 | Another master asks for the bus |
| rel_gnt | output | 1 | Bus released |
| ad_o | output | 16 | Shared address/data lines, drive value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_i | input | 16 | Shared lines, sampled value |
| ad_pull_en | output | 1 | Pull-up enable for shared lines |
| addr_hi | output | 8 | Address bits 23..16 |
| ale | output | 1 | Address latch strobe |
| cs_n | output | 4 | Chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 2 | Byte-lane write strobes, active low |

## Verification
Pin outputs follow the registered state directly. For this reason the address phase shows up one clock after the accepting edge, and each data clock follows it in turn. The bench samples every clock at the falling edge and checks each address phase, strobe and pin rule as it happens. Read bytes are captured at the edge that ends the last data clock. So rdata and done are checked on the clock that is N*(W+3) falling edges after acceptance. The bench counts exactly that many edges from the accepting edge and compares the count with the position of the pulse. The release grant is due on the clock right after the final gap clock, or one clock after rel_req while idle, and it is checked at that edge.

// File: rtl/nbus_pkg.sv
package nbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_GAP  = 3'd3,
    ST_REL  = 3'd4
  } seq_state_e;

  localparam logic [1:0] STRAP_BLK0_NARROW = 2'b10;
  localparam int         BYTES_PER_REQ     = 4;
  localparam int         PIN_W             = 16;

endpackage

// File: rtl/nbus_blkcfg.sv
module nbus_blkcfg
  import nbus_pkg::*;
#(
  parameter int NBLK   = 4,
  parameter int WAIT_W = 3,
  localparam int BSEL_W = $clog2(NBLK)
) (
  input  logic [BSEL_W-1:0]      blk,
  input  logic [1:0]             strap_mode,
  input  logic [NBLK-2:0]        cfg_bw,
  input  logic [NBLK*WAIT_W-1:0] cfg_wait,
  output logic                   narrow,
  output logic [WAIT_W-1:0]      wait_val
);

  logic [NBLK-1:0] narrow_vec;

  // block 0 width comes from the straps, the rest from width bits
  assign narrow_vec[0] = (strap_mode == STRAP_BLK0_NARROW);

  for (genvar gi = 1; gi < NBLK; gi++) begin : g_bw
    assign narrow_vec[gi] = ~cfg_bw[gi-1];
  end

  assign narrow   = narrow_vec[blk];
  assign wait_val = cfg_wait[blk*WAIT_W +: WAIT_W];

endmodule

// File: rtl/nbus_beatgen.sv
module nbus_beatgen (
  input  logic [1:0] size,
  input  logic       narrow,
  input  logic [1:0] addr_lo,
  input  logic [1:0] beat,
  output logic [1:0] beat_lo,
  output logic [1:0] lane_en,
  output logic       last
);

  logic [2:0] nbeats;

  always_comb begin
    if (narrow) begin
      lane_en = 2'b01;
      if (size[1]) begin
        nbeats  = 3'd4;
        beat_lo = beat;
      end else if (size[0]) begin
        nbeats  = 3'd2;
        beat_lo = {addr_lo[1], beat[0]};
      end else begin
        nbeats  = 3'd1;
        beat_lo = addr_lo;
      end
    end else begin
      if (size[1]) begin
        nbeats  = 3'd2;
        beat_lo = {beat[0], 1'b0};
        lane_en = 2'b11;
      end else if (size[0]) begin
        nbeats  = 3'd1;
        beat_lo = {addr_lo[1], 1'b0};
        lane_en = 2'b11;
      end else begin
        nbeats  = 3'd1;
        beat_lo = addr_lo;
        lane_en = addr_lo[0] ? 2'b10 : 2'b01;
      end
    end
    last = ({1'b0, beat} == (nbeats - 3'd1));
  end

endmodule

// File: rtl/nbus_fsm.sv
module nbus_fsm
  import nbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              rel_req,
  input  logic              last,
  input  logic [WAIT_W-1:0] wait_q,
  output seq_state_e        state,
  output logic [1:0]        beat,
  output logic              accept,
  output logic              data_end,
  output logic              done,
  output logic              req_ready
);

  seq_state_e        state_q, state_d;
  logic [1:0]        beat_q, beat_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic              done_q, done_d;
  logic              beat_en, wcnt_en;

  assign req_ready = (state_q == ST_IDLE) && !rel_req;
  assign accept    = req_ready && req_valid;
  assign data_end  = (state_q == ST_DATA) && (wcnt_q == wait_q);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    wcnt_d  = wcnt_q;
    done_d  = 1'b0;
    beat_en = 1'b0;
    wcnt_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rel_req) begin
          state_d = ST_REL;
        end else if (req_valid) begin
          state_d = ST_ADDR;
          beat_d  = 2'd0;
          beat_en = 1'b1;
        end
      end
      ST_ADDR: begin
        state_d = ST_DATA;
        wcnt_d  = '0;
        wcnt_en = 1'b1;
      end
      ST_DATA: begin
        if (data_end) begin
          state_d = ST_GAP;
          done_d  = last;
        end else begin
          wcnt_d  = wcnt_q + 1'b1;
          wcnt_en = 1'b1;
        end
      end
      ST_GAP: begin
        if (last) begin
          state_d = rel_req ? ST_REL : ST_IDLE;
        end else begin
          state_d = ST_ADDR;
          beat_d  = beat_q + 2'd1;
          beat_en = 1'b1;
        end
      end
      ST_REL: begin
        if (!rel_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (wcnt_en) begin
      wcnt_q <= wcnt_d;
    end
  end

  assign state = state_q;
  assign beat  = beat_q;
  assign done  = done_q;

  // R5: the wait counter stays within the latched wait value
  p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (wcnt_q <= wait_q));

  // R12: completion is a single-clock pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: the grant only starts from idle or from the final gap clock
  p_gnt_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_REL) && ($past(state_q) != ST_REL)) |->
      (($past(state_q) == ST_IDLE) || (($past(state_q) == ST_GAP) && $past(last))));

endmodule

// File: rtl/nbus_rdasm.sv
module nbus_rdasm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap,
  input  logic        narrow,
  input  logic [1:0]  beat_lo,
  input  logic [1:0]  lane_en,
  input  logic [15:0] ad_i,
  output logic [31:0] rdata
);

  logic [31:0] rdata_q, rdata_d;
  logic        rdata_en;

  assign rdata_en = clr || cap;

  always_comb begin
    rdata_d = rdata_q;
    if (clr) begin
      rdata_d = '0;
    end else if (cap) begin
      if (narrow) begin
        rdata_d[8*beat_lo +: 8] = ad_i[7:0];
      end else if (lane_en == 2'b11) begin
        rdata_d[16*beat_lo[1] +: 16] = ad_i;
      end else begin
        rdata_d[8*beat_lo +: 8] = beat_lo[0] ? ad_i[15:8] : ad_i[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/nbus_seq.sv
module nbus_seq
  import nbus_pkg::*;
#(
  parameter int AW     = 24,
  parameter int NBLK   = 4,
  parameter int WAIT_W = 3,
  localparam int BSEL_W = $clog2(NBLK),
  localparam int HI_W   = AW - PIN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AW-1:0]          req_addr,
  input  logic [1:0]             req_size,
  input  logic                   req_write,
  input  logic [31:0]            req_wdata,
  input  logic [BSEL_W-1:0]      req_blk,
  output logic                   done,
  output logic [31:0]            rdata,
  input  logic [1:0]             strap_mode,
  input  logic [NBLK-2:0]        cfg_bw,
  input  logic [NBLK*WAIT_W-1:0] cfg_wait,
  input  logic                   cfg_rel_pullup,
  input  logic                   rel_req,
  output logic                   rel_gnt,
  output logic [PIN_W-1:0]       ad_o,
  output logic                   ad_oe,
  input  logic [PIN_W-1:0]       ad_i,
  output logic                   ad_pull_en,
  output logic [HI_W-1:0]        addr_hi,
  output logic                   ale,
  output logic [NBLK-1:0]        cs_n,
  output logic                   rd_n,
  output logic [1:0]             we_n
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // configuration of the requested block
  logic              cfg_narrow;
  logic [WAIT_W-1:0] cfg_wval;

  nbus_blkcfg #(.NBLK(NBLK), .WAIT_W(WAIT_W)) u_blkcfg (
    .blk       (req_blk),
    .strap_mode(strap_mode),
    .cfg_bw    (cfg_bw),
    .cfg_wait  (cfg_wait),
    .narrow    (cfg_narrow),
    .wait_val  (cfg_wval)
  );

  // request held for the whole access
  logic [AW-1:0]     addr_q;
  logic [1:0]        size_q;
  logic              write_q;
  logic [31:0]       wdata_q;
  logic [BSEL_W-1:0] blk_q;
  logic              narrow_q;
  logic [WAIT_W-1:0] wait_q;
  logic              accept;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q   <= '0;
      size_q   <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      blk_q    <= '0;
      narrow_q <= 1'b0;
      wait_q   <= '0;
    end else if (accept) begin
      addr_q   <= req_addr;
      size_q   <= req_size;
      write_q  <= req_write;
      wdata_q  <= req_wdata;
      blk_q    <= req_blk;
      narrow_q <= cfg_narrow;
      wait_q   <= cfg_wval;
    end
  end

  // sequencing
  seq_state_e state;
  logic [1:0] beat;
  logic [1:0] beat_lo;
  logic [1:0] lane_en;
  logic       last;
  logic       data_end;

  nbus_beatgen u_beatgen (
    .size   (size_q),
    .narrow (narrow_q),
    .addr_lo(addr_q[1:0]),
    .beat   (beat),
    .beat_lo(beat_lo),
    .lane_en(lane_en),
    .last   (last)
  );

  nbus_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s),
    .req_valid(req_valid),
    .rel_req  (rel_req),
    .last     (last),
    .wait_q   (wait_q),
    .state    (state),
    .beat     (beat),
    .accept   (accept),
    .data_end (data_end),
    .done     (done),
    .req_ready(req_ready)
  );

  nbus_rdasm u_rdasm (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr    (accept),
    .cap    (data_end && !write_q),
    .narrow (narrow_q),
    .beat_lo(beat_lo),
    .lane_en(lane_en),
    .ad_i   (ad_i),
    .rdata  (rdata)
  );

  // pin decode
  logic in_addr, in_data, sel_active;
  logic [7:0]  wr_byte;
  logic [15:0] wr_half;

  assign in_addr    = (state == ST_ADDR);
  assign in_data    = (state == ST_DATA);
  assign sel_active = in_addr || in_data;
  assign wr_byte    = wdata_q[8*beat_lo +: 8];
  assign wr_half    = wdata_q[16*beat_lo[1] +: 16];

  always_comb begin
    ad_o = '0;
    if (in_addr) begin
      ad_o = {addr_q[PIN_W-1:2], beat_lo};
    end else if (in_data && write_q) begin
      ad_o = narrow_q ? {8'h00, wr_byte} : wr_half;
    end
  end

  assign ad_oe      = in_addr || (in_data && write_q);
  assign addr_hi    = in_addr ? addr_q[AW-1:PIN_W] : '0;
  assign ale        = in_addr;
  assign rd_n       = !(in_data && !write_q);
  assign we_n       = (in_data && write_q) ? ~lane_en : 2'b11;
  assign rel_gnt    = (state == ST_REL);
  assign ad_pull_en = rel_gnt && cfg_rel_pullup;

  for (genvar gb = 0; gb < NBLK; gb++) begin : g_cs
    assign cs_n[gb] = !(sel_active && (blk_q == BSEL_W'(gb)));
  end

  // R6: shared lines float while no chip select is active
  p_float_idle_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (&cs_n) |-> !ad_oe);

  // R7: upper address zero outside address phase
  p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !ale |-> (addr_hi == '0));

  // R4: at most one chip select active
  p_one_cs_r4: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(~cs_n));

  // R2: read and write strobes exclusive
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !(!rd_n && (we_n != 2'b11)));

  // R11: released bus is quiet
  p_rel_quiet_r11: assert property (@(posedge clk) disable iff (!rst_s)
    rel_gnt |-> ((&cs_n) && !ad_oe && !req_ready));

  // R4: address phase lasts exactly one clock
  p_ale_single_r4: assert property (@(posedge clk) disable iff (!rst_s)
    ale |=> !ale);

endmodule

// File: tb/nbus_seq_tb.sv
module nbus_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic [1:0]  req_blk;
  logic        done;
  logic [31:0] rdata;
  logic [1:0]  strap_mode;
  logic [2:0]  cfg_bw;
  logic [11:0] cfg_wait;
  logic        cfg_rel_pullup;
  logic        rel_req;
  logic        rel_gnt;
  logic [15:0] ad_o;
  logic        ad_oe;
  logic [15:0] ad_i;
  logic        ad_pull_en;
  logic [7:0]  addr_hi;
  logic        ale;
  logic [3:0]  cs_n;
  logic        rd_n;
  logic [1:0]  we_n;

  int n_tests;
  int n_fail;
  bit finished;

  nbus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_blk(req_blk), .done(done), .rdata(rdata),
    .strap_mode(strap_mode), .cfg_bw(cfg_bw), .cfg_wait(cfg_wait),
    .cfg_rel_pullup(cfg_rel_pullup), .rel_req(rel_req), .rel_gnt(rel_gnt),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ad_pull_en(ad_pull_en),
    .addr_hi(addr_hi), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [15:0] x);
    return x[7:0] ^ {x[11:8], x[15:12]} ^ 8'h3C;
  endfunction

  function automatic bit blk_narrow(input int b);
    if (b == 0) return (strap_mode == 2'b10);
    return !cfg_bw[b-1];
  endfunction

  task automatic run_xfer(input int blk, input int sz, input int wr,
                          input int off, input int seed, input int rel_at);
    logic [23:0] a;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [1:0]  bl [4];
    logic [15:0] exp_ad [4];
    logic [1:0]  exp_we [4];
    int dcnt [4];
    int nb, w, cnt, seen, addr_bad, wr_bad, viol, gnt_bad, dl_bad;
    bit nar;
    logic [15:0] lat, fa;
    nar = blk_narrow(blk);
    w   = int'(cfg_wait[blk*3 +: 3]);
    if (nar) nb = (sz == 2) ? 4 : ((sz == 1) ? 2 : 1);
    else     nb = (sz == 2) ? 2 : 1;
    a  = {8'(8'h81 + 8'(seed)), 8'(8'hC3 ^ 8'(seed)), 6'(seed), 2'(off)};
    wd = 32'hA1B2C3D4 ^ {4{8'(seed)}};
    exp_rd = '0;
    for (int k = 0; k < 4; k++) begin
      dcnt[k] = 0;
      if (nar) begin
        if (sz == 2)      bl[k] = 2'(k);
        else if (sz == 1) bl[k] = {a[1], 1'(k)};
        else              bl[k] = a[1:0];
        exp_ad[k] = {8'h00, wd[8*bl[k] +: 8]};
        exp_we[k] = 2'b10;
      end else begin
        if (sz == 2)      bl[k] = {1'(k), 1'b0};
        else if (sz == 1) bl[k] = {a[1], 1'b0};
        else              bl[k] = a[1:0];
        exp_ad[k] = wd[16*bl[k][1] +: 16];
        exp_we[k] = (sz == 0) ? (bl[k][0] ? 2'b01 : 2'b10) : 2'b00;
      end
      if (k < nb) begin
        fa = {a[15:2], bl[k]};
        if (nar || sz == 0) exp_rd[8*bl[k] +: 8] = memf(fa);
        else exp_rd[16*bl[k][1] +: 16] = {memf(fa | 16'h1), memf(fa & ~16'h1)};
      end
    end
    // R12: idle and ready before the request
    chk(req_ready == 1'b1, "R12 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_write = 1'(wr);
    req_wdata = wd; req_blk = 2'(blk);
    cnt = 0; seen = 0; addr_bad = 0; wr_bad = 0; viol = 0; gnt_bad = 0; lat = '0;
    do begin
      @(negedge clk);
      cnt++;
      req_valid = 1'b0;
      if (rel_at > 0 && cnt == rel_at) rel_req = 1'b1;
      if (&cs_n && ad_oe) viol++;
      if (!ale && addr_hi != 8'h00) viol++;
      if (rel_gnt) gnt_bad++;
      if (ale) begin
        if (seen < 4) begin
          if (ad_o != {a[15:2], bl[seen]} || addr_hi != a[23:16] ||
              cs_n != ~(4'b1 << blk) || !ad_oe) addr_bad++;
        end else addr_bad++;
        lat = ad_o;
        seen++;
      end
      ad_i = 16'hDEAD;
      if (!rd_n) begin
        if (seen >= 1) dcnt[seen-1]++;
        if (wr != 0 || ad_oe) wr_bad++;
        ad_i = nar ? {8'hEE, memf(lat)} : {memf(lat | 16'h1), memf(lat & ~16'h1)};
      end
      if (we_n != 2'b11) begin
        if (seen >= 1) begin
          dcnt[seen-1]++;
          if (ad_o != exp_ad[seen-1] || we_n != exp_we[seen-1] || !ad_oe) wr_bad++;
        end
        if (wr == 0 || !rd_n) wr_bad++;
      end
    end while (!done && cnt < 400);
    // R4: completion timing; R8 and R9 choose the cycle count
    chk(cnt == nb*(w+3), "R4 R8 done timing", 32'(cnt), 32'(nb*(w+3)));
    chk(seen == nb && addr_bad == 0, "R1 R9 address sequence",
        32'(addr_bad), 32'd0);
    dl_bad = 0;
    for (int k = 0; k < nb; k++) if (dcnt[k] != w + 1) dl_bad++;
    chk(dl_bad == 0, "R5 data phase length", 32'(dcnt[0]), 32'(w + 1));
    if (wr == 0) chk(rdata == exp_rd, "R3 R9 read assembly", rdata, exp_rd);
    else         chk(wr_bad == 0, "R2 R9 write lanes", 32'(wr_bad), 32'd0);
    chk(viol == 0, "R6 R7 pin rules", 32'(viol), 32'd0);
    chk(gnt_bad == 0, "R10 no grant mid access", 32'(gnt_bad), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R12 done single pulse", 32'(done), 32'd0);
    if (rel_at > 0) begin
      chk(rel_gnt == 1'b1, "R10 grant after last cycle", 32'(rel_gnt), 32'd1);
      rel_req = 1'b0;
      @(negedge clk);
    end else begin
      chk(req_ready == 1'b1, "R12 ready after done", 32'(req_ready), 32'd1);
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_wdata = '0; req_blk = '0; rel_req = 1'b0;
    cfg_rel_pullup = 1'b1; ad_i = '0;
    strap_mode = 2'b10; cfg_bw = 3'b010;
    cfg_wait = {3'd5, 3'd2, 3'd1, 3'd0};
    repeat (3) @(negedge clk);
    // reset state
    chk(&cs_n && !ad_oe && !done && !rel_gnt, "R6 reset pins",
        {27'd0, cs_n, ad_oe}, 32'h1E);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && rdata == 32'd0, "R12 ready after reset", rdata, 32'd0);

    begin : sweep
      int seed;
      seed = 0;
      for (int pass = 0; pass < 2; pass++) begin
        if (pass == 1) begin
          strap_mode = 2'b00; cfg_bw = 3'b101;
          cfg_wait = {3'd0, 3'd7, 3'd3, 3'd1};
        end
        for (int b = 0; b < 4; b++)
          for (int s = 0; s < 3; s++)
            for (int wr = 0; wr < 2; wr++)
              for (int off = 0; off < 4; off += (1 << s)) begin
                run_xfer(b, s, wr, off, seed, 0);
                seed++;
              end
      end
    end

    // R13: release wins over a simultaneous request; R11 quiet bus
    req_valid = 1'b1; req_blk = 2'd1; req_size = 2'd0; req_write = 1'b1;
    rel_req = 1'b1; cfg_rel_pullup = 1'b1;
    @(negedge clk);
    chk(rel_gnt == 1'b1 && req_ready == 1'b0, "R13 release priority",
        {30'd0, rel_gnt, req_ready}, 32'd2);
    chk(ad_pull_en == 1'b1, "R11 pull-up while released", 32'(ad_pull_en), 32'd1);
    begin : hold_rel
      int bad;
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (!(&cs_n) || ad_oe || req_ready || !rel_gnt) bad++;
      end
      chk(bad == 0, "R11 request ignored while released", 32'(bad), 32'd0);
    end
    cfg_rel_pullup = 1'b0;
    @(negedge clk);
    chk(ad_pull_en == 1'b0, "R11 floating while released", 32'(ad_pull_en), 32'd0);
    req_valid = 1'b0; rel_req = 1'b0;
    @(negedge clk);
    chk(rel_gnt == 1'b0 && req_ready == 1'b1 && (&cs_n), "R11 bus returned",
        {31'd0, rel_gnt}, 32'd0);

    // R10: release asked early in a split access is deferred to its end
    strap_mode = 2'b10; cfg_bw = 3'b000; cfg_wait = {3'd2, 3'd1, 3'd3, 3'd0};
    run_xfer(2, 2, 0, 0, 77, 1);
    run_xfer(1, 1, 1, 2, 91, 3);
    run_xfer(0, 2, 1, 0, 55, 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule